// File: doc/BRIEF.md
# Tagged Custom-Operation Execution Unit

This unit sits next to a processor's integer datapath and executes custom register-type instructions. Each issued instruction names an 11-bit logical operation number and supplies two source operands. The unit holds exactly one loaded configuration, labelled with the operation number it realises. When the requested number equals that label, the unit returns a result computed combinationally in the same cycle. When the numbers differ, or nothing has been loaded, it raises a miss trap and returns no result, so that software can load the wanted configuration and retry.

A configuration is a short chain of primitive operations (add, subtract, bitwise logic, shifts, compares). The first stage combines operand A with operand B, and each later stage combines the previous stage's value with operand B. Configurations are written through a load port and take effect on the following clock edge. Apart from the loaded configuration, the unit holds nothing between operations, so a context switch needs no save or restore of it.

Top module: `custom_op_unit`

## Requirements
- R1: After reset no configuration is valid, and every issued operation raises `miss_trap` until a load has completed.
- R2: When `iss_valid` is high and `iss_fid` equals the loaded label, `res_valid` is high in the same cycle and `res_data` equals the chained result: stage 0 computes op0(A,B), stage 1 computes op1(stage0,B).
- R3: When `iss_valid` is high and `iss_fid` differs from the loaded label, `miss_trap` is high, `res_valid` is low and `res_data` is zero.
- R4: With `iss_valid` low, both `res_valid` and `miss_trap` are low.
- R5: A write with `cfg_we` high takes effect on the next clock edge. An operation issued in the same cycle as a load is judged against the configuration that was loaded before.
- R6: `res_valid` and `miss_trap` are never high in the same cycle.
- R7: Primitive codes (4 bits each, stage 0 in `cfg_ops[3:0]`, stage 1 in `cfg_ops[7:4]`): 0 pass first input, 1 add, 2 subtract (first minus second), 3 and, 4 or, 5 xor, 6 shift left, 7 logical shift right, 8 arithmetic shift right, 9 signed less-than (result 1 or 0), 10 unsigned less-than.
- R8: Shift primitives use only the low log2(width) bits of the second input as the shift amount.
- R9: Primitive codes 11 to 15 produce zero.
- R10: `res_data` is zero in every cycle in which `res_valid` is low.
- R11: The label compare covers all 11 bits, including the top bit and the all-ones number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | A custom operation is issued this cycle |
| iss_fid | input | 11 | Requested logical operation number |
| iss_a | input | 32 | First source operand |
| iss_b | input | 32 | Second source operand |
| res_valid | output | 1 | Result valid (label hit) |
| res_data | output | 32 | Result value, zero when not valid |
| miss_trap | output | 1 | Configuration miss, software must load |
| cfg_we | input | 1 | Load a new configuration |
| cfg_fid | input | 11 | Label of the configuration being loaded |
| cfg_ops | input | 8 | Primitive codes, 4 bits per stage |

## Verification
A configuration load and an issued operation can occur in the same cycle. The bench provokes this by raising `cfg_we` with a new label while issuing both the old and the new label. The old label must hit with the old arithmetic, and the new label must miss. In the cycle after the load, the new label must hit with the new arithmetic and the old label must trap.

// File: rtl/cou_pkg.sv
package cou_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_PASS = 4'd0;
  localparam logic [OPW-1:0] OP_ADD  = 4'd1;
  localparam logic [OPW-1:0] OP_SUB  = 4'd2;
  localparam logic [OPW-1:0] OP_AND  = 4'd3;
  localparam logic [OPW-1:0] OP_OR   = 4'd4;
  localparam logic [OPW-1:0] OP_XOR  = 4'd5;
  localparam logic [OPW-1:0] OP_SLL  = 4'd6;
  localparam logic [OPW-1:0] OP_SRL  = 4'd7;
  localparam logic [OPW-1:0] OP_SRA  = 4'd8;
  localparam logic [OPW-1:0] OP_SLT  = 4'd9;
  localparam logic [OPW-1:0] OP_SLTU = 4'd10;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HIT  = 2'd1,
    LK_MISS = 2'd2
  } lookup_e;
endpackage

// File: rtl/cou_cfg_store.sv
module cou_cfg_store #(
  parameter int FIDW = 11,
  parameter int CFGW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [FIDW-1:0] wr_fid,
  input  logic [CFGW-1:0] wr_ops,
  output logic            loaded,
  output logic [FIDW-1:0] tag,
  output logic [CFGW-1:0] ops
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      tag    <= '0;
      ops    <= '0;
    end else if (we) begin
      loaded <= 1'b1;
      tag    <= wr_fid;
      ops    <= wr_ops;
    end
  end

  // R5: a load is visible on the next edge
  p_load_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (loaded && tag == $past(wr_fid) && ops == $past(wr_ops)));

  // R5: without a load the configuration holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(tag) && $stable(ops) && $stable(loaded)));
endmodule

// File: rtl/cou_tag_cmp.sv
module cou_tag_cmp
  import cou_pkg::*;
#(
  parameter int FIDW = 11
) (
  input  logic            req,
  input  logic [FIDW-1:0] req_fid,
  input  logic            loaded,
  input  logic [FIDW-1:0] tag,
  output lookup_e         outcome
);
  logic same;
  assign same = (req_fid == tag);

  always_comb begin
    if (!req)                 outcome = LK_IDLE;
    else if (loaded && same)  outcome = LK_HIT;
    else                      outcome = LK_MISS;
  end
endmodule

// File: rtl/cou_alu.sv
module cou_alu
  import cou_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [W-1:0]   z
);
  localparam int SHW = $clog2(W);

  function automatic logic [W-1:0] prim(input logic [OPW-1:0] code,
                                        input logic [W-1:0] p,
                                        input logic [W-1:0] q);
    logic [SHW-1:0] amt;
    amt = q[SHW-1:0];
    case (code)
      OP_PASS: prim = p;
      OP_ADD:  prim = p + q;
      OP_SUB:  prim = p - q;
      OP_AND:  prim = p & q;
      OP_OR:   prim = p | q;
      OP_XOR:  prim = p ^ q;
      OP_SLL:  prim = p << amt;
      OP_SRL:  prim = p >> amt;
      OP_SRA:  prim = $unsigned($signed(p) >>> amt);
      OP_SLT:  prim = {{(W-1){1'b0}}, ($signed(p) < $signed(q))};
      OP_SLTU: prim = {{(W-1){1'b0}}, (p < q)};
      default: prim = '0;
    endcase
  endfunction

  assign z = prim(op, x, y);
endmodule

// File: rtl/custom_op_unit.sv
module custom_op_unit
  import cou_pkg::*;
#(
  parameter int W      = 32,
  parameter int FIDW   = 11,
  parameter int NSTAGE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iss_valid,
  input  logic [FIDW-1:0]       iss_fid,
  input  logic [W-1:0]          iss_a,
  input  logic [W-1:0]          iss_b,
  output logic                  res_valid,
  output logic [W-1:0]          res_data,
  output logic                  miss_trap,
  input  logic                  cfg_we,
  input  logic [FIDW-1:0]       cfg_fid,
  input  logic [NSTAGE*OPW-1:0] cfg_ops
);
  localparam int CFGW = NSTAGE * OPW;

  logic            cfg_loaded;
  logic [FIDW-1:0] cfg_tag;
  logic [CFGW-1:0] cfg_sel;
  lookup_e         outcome;
  logic            ev_hit;
  logic            ev_miss;
  logic [W-1:0]    chain [NSTAGE+1];

  cou_cfg_store #(.FIDW(FIDW), .CFGW(CFGW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_fid(cfg_fid),
    .wr_ops(cfg_ops), .loaded(cfg_loaded), .tag(cfg_tag), .ops(cfg_sel)
  );

  cou_tag_cmp #(.FIDW(FIDW)) u_cmp (
    .req(iss_valid), .req_fid(iss_fid), .loaded(cfg_loaded),
    .tag(cfg_tag), .outcome(outcome)
  );

  assign ev_hit  = (outcome == LK_HIT);
  assign ev_miss = (outcome == LK_MISS);

  assign chain[0] = iss_a;
  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    cou_alu #(.W(W)) u_alu (
      .op(cfg_sel[k*OPW +: OPW]), .x(chain[k]), .y(iss_b), .z(chain[k+1])
    );
  end

  assign res_valid = ev_hit;
  assign miss_trap = ev_miss;
  assign res_data  = ev_hit ? chain[NSTAGE] : '0;

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && miss_trap));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> (!res_valid && !miss_trap));

  p_unloaded_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !cfg_loaded) |-> miss_trap);

  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_data == '0));

  p_hit_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (iss_fid == cfg_tag && cfg_loaded));

  p_issue_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (res_valid || miss_trap));
endmodule

// File: tb/sim_custom_op_unit.sv
`timescale 1ns/1ps
module sim_custom_op_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [10:0] iss_fid = '0;
  logic [31:0] iss_a = '0, iss_b = '0;
  logic        res_valid, miss_trap;
  logic [31:0] res_data;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_fid = '0;
  logic [7:0]  cfg_ops = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  custom_op_unit u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_fid(iss_fid),
    .iss_a(iss_a), .iss_b(iss_b), .res_valid(res_valid), .res_data(res_data),
    .miss_trap(miss_trap), .cfg_we(cfg_we), .cfg_fid(cfg_fid), .cfg_ops(cfg_ops)
  );

  // {cfg_fid, op1, op0, iss_fid, a, b, hit, expected result}
  localparam int NV = 17;
  localparam logic [126:0] VEC [NV] = '{
    {11'd5,   4'd0,  4'd1,  11'd5,   32'd10,         32'd20,         1'b1, 32'd30},
    {11'd7,   4'd0,  4'd2,  11'd7,   32'd5,          32'd7,          1'b1, 32'hFFFFFFFE},
    {11'd100, 4'd0,  4'd3,  11'd100, 32'hF0F000FF,   32'h0FF00F0F,   1'b1, 32'h00F0000F},
    {11'd101, 4'd0,  4'd4,  11'd101, 32'h12000000,   32'h00000034,   1'b1, 32'h12000034},
    {11'd102, 4'd0,  4'd5,  11'd102, 32'hFFFF0000,   32'hFF00FF00,   1'b1, 32'h00FFFF00},
    {11'd103, 4'd0,  4'd6,  11'd103, 32'd1,          32'd36,         1'b1, 32'h00000010},
    {11'd104, 4'd0,  4'd7,  11'd104, 32'h80000000,   32'd31,         1'b1, 32'd1},
    {11'd105, 4'd0,  4'd8,  11'd105, 32'h80000000,   32'd4,          1'b1, 32'hF8000000},
    {11'd106, 4'd0,  4'd9,  11'd106, 32'hFFFFFFFF,   32'd1,          1'b1, 32'd1},
    {11'd107, 4'd0,  4'd10, 11'd107, 32'hFFFFFFFF,   32'd1,          1'b1, 32'd0},
    {11'd200, 4'd5,  4'd1,  11'd200, 32'd3,          32'd5,          1'b1, 32'd13},
    {11'd201, 4'd2,  4'd6,  11'd201, 32'd3,          32'd2,          1'b1, 32'd10},
    {11'd202, 4'd0,  4'd12, 11'd202, 32'd77,         32'd9,          1'b1, 32'd0},
    {11'd203, 4'd14, 4'd1,  11'd203, 32'd77,         32'd9,          1'b1, 32'd0},
    {11'h400, 4'd0,  4'd1,  11'h000, 32'd1,          32'd1,          1'b0, 32'd0},
    {11'd9,   4'd0,  4'd1,  11'd8,   32'd1,          32'd1,          1'b0, 32'd0},
    {11'h7FF, 4'd0,  4'd1,  11'h7FF, 32'd1,          32'd1,          1'b1, 32'd2}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load(input logic [10:0] fid, input logic [7:0] ops);
    @(negedge clk);
    iss_valid = 1'b0;
    cfg_we = 1'b1; cfg_fid = fid; cfg_ops = ops;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [10:0] fid, input logic [31:0] a, input logic [31:0] b);
    iss_valid = 1'b1; iss_fid = fid; iss_a = a; iss_b = b;
    #1;
  endtask

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4 and R1: reset state
    #1;
    chk("R4 idle res_valid during reset", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(11'd0, 32'd4, 32'd4);
    chk("R1 miss after reset", {31'd0, miss_trap}, 32'd1);
    chk("R1 no result after reset", {31'd0, res_valid}, 32'd0);
    chk("R10 data zero on miss", res_data, 32'd0);
    @(negedge clk);
    iss_valid = 1'b0; #1;
    chk("R4 idle no trap", {31'd0, miss_trap}, 32'd0);

    // vector table: R2 R3 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      logic [126:0] v;
      v = VEC[i];
      load(v[126:116], {v[115:112], v[111:108]});
      issue(v[107:97], v[96:65], v[64:33]);
      chk($sformatf("R2/R3/R7 vec%0d valid", i), {31'd0, res_valid}, {31'd0, v[32]});
      chk($sformatf("R3/R6 vec%0d trap", i), {31'd0, miss_trap}, {31'd0, ~v[32]});
      chk($sformatf("R7/R8/R9/R11 vec%0d data", i), res_data, v[31:0]);
    end

    // R5: load and issue in the same cycle
    load(11'd5, 8'h01);           // add
    @(negedge clk);
    cfg_we = 1'b1; cfg_fid = 11'd6; cfg_ops = 8'h02;  // sub
    issue(11'd5, 32'd9, 32'd4);
    chk("R5 old label hits during load", {31'd0, res_valid}, 32'd1);
    chk("R5 old arithmetic during load", res_data, 32'd13);
    issue(11'd6, 32'd9, 32'd4);
    chk("R5 new label misses during load", {31'd0, miss_trap}, 32'd1);
    @(negedge clk);
    cfg_we = 1'b0;
    issue(11'd6, 32'd9, 32'd4);
    chk("R5 new label hits after load", res_data, 32'd5);
    issue(11'd5, 32'd9, 32'd4);
    chk("R5 old label traps after load", {31'd0, miss_trap}, 32'd1);
    chk("R6 no result on trap", {31'd0, res_valid}, 32'd0);

    // R1: reset drops the configuration
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    issue(11'd6, 32'd9, 32'd4);
    chk("R1 miss after second reset", {31'd0, miss_trap}, 32'd1);
    @(negedge clk);
    iss_valid = 1'b0;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule